// File: doc/BRIEF.md
# Hardware Call Stack with Return Sequencer

This block is the stack of a small processor. An 8-bit stack pointer indexes a 256-byte internal RAM. The execution core issues one command at a time: push a byte, pop a byte, save a 16-bit program counter for a subroutine call, or take a 16-bit return address back for a plain return or an interrupt return. The stack grows upward. A push moves the pointer up and then writes. A pop reads and then moves the pointer down.

Each command keeps the unit busy for two clock cycles. A one-cycle `done` pulse then presents the result. For a pop, the popped byte can be routed back into the stack pointer itself. For an interrupt return, a one-cycle pulse tells the interrupt controller to drop its highest in-service level. The status word is not restored. Instruction fetch, interrupt arbitration and the program-counter register live outside this block.

Top module: `stk_unit`

## Requirements
- R1: After reset the stack pointer reads 07h, and `busy` and `done` are low.
- R2: A push (command code 1) first raises the pointer by one and then writes `push_byte` at the new pointer. From pointer 09h, pushing 23h and then 01h leaves the pointer at 0Bh with 23h at 0Ah and 01h at 0Bh.
- R3: A pop (command code 2) reads the byte at the pointer, lowers the pointer by one and presents the byte on `pop_byte`. From pointer 32h over bytes 20h, 23h, 01h at 30h..32h, two pops yield 01h (high) and then 23h (low), which form the pointer 0123h, and leave the pointer at 30h.
- R4: A pop with `pop_to_sp` high ends with the stack pointer equal to the popped byte, because the decrement is overwritten. From pointer 30h holding 20h, the pointer becomes 20h.
- R5: A call save (command code 3) writes `call_pc[7:0]` at pointer+1 and then `call_pc[15:8]` at pointer+2, leaving the pointer raised by two.
- R6: A return (command code 4) takes the high byte from the pointer and the low byte from pointer-1, puts {high,low} on `ret_pc` and leaves the pointer lowered by two. From 0Bh with 23h at 0Ah and 01h at 0Bh it returns 0123h and the pointer becomes 09h.
- R7: An interrupt return (command code 5) behaves as R6 and also raises `isr_level_clr` for exactly the `done` cycle. A plain return never raises it.
- R8: An accepted command holds `busy` high for exactly two cycles. `done` is a single-cycle pulse in the cycle that follows, and the result and the new pointer are valid in that cycle.
- R9: A command is accepted only while `busy` is low. Requests made while busy, and codes 0, 6 and 7, are ignored: they produce no `done` and leave the pointer unchanged.
- R10: The pointer wraps modulo 256. A push at FFh writes at 00h, and a pop at 00h leaves FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd | input | 3 | Command code: 1 push, 2 pop, 3 call save, 4 return, 5 interrupt return |
| push_byte | input | 8 | Byte to push |
| call_pc | input | 16 | Program counter to save on a call |
| pop_to_sp | input | 1 | Pop destination is the stack pointer |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pop_byte | output | 8 | Byte from the last pop |
| ret_pc | output | 16 | Address from the last return |
| isr_level_clr | output | 1 | Clear highest in-service interrupt level |
| sp_value | output | 8 | Current stack pointer |

## Verification
The assertions assume the core never reads a RAM location it has not written: a location that was never written has no defined value, so a pop or return from it would put an unknown value on the outputs. They also assume that `cmd` carries a defined code whenever `cmd_valid` is high. The stimulus meets both assumptions. It builds every stack image with pushes before popping it, and it sets the pointer only by pushing a value and popping it into the pointer. It holds `cmd_valid` low except when it deliberately requests a command, including the cases that must be ignored.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int PTR_W  = 8;
  localparam int BYTE_W = 8;
  localparam int PC_W   = 2 * BYTE_W;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PUSH = 3'd1,
    CMD_POP  = 3'd2,
    CMD_CALL = 3'd3,
    CMD_RET  = 3'd4,
    CMD_RETI = 3'd5
  } stk_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_A    = 2'd1,
    ST_B    = 2'd2
  } stk_state_e;

  function automatic logic [PTR_W-1:0] ptr_up(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_down(input logic [PTR_W-1:0] p);
    return p - PTR_W'(1);
  endfunction

  function automatic logic [PC_W-1:0] pc_join(input logic [BYTE_W-1:0] hi,
                                              input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic cmd_known(input logic [2:0] c);
    return (c >= 3'(CMD_PUSH)) && (c <= 3'(CMD_RETI));
  endfunction
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int W = 8,
  parameter logic [W-1:0] RESET_VAL = 8'h07
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] sp
);
  always_ff @(posedge clk) begin
    if (!rst_n)    sp <= RESET_VAL;
    else if (load) sp <= load_val;
    else if (inc)  sp <= sp + W'(1);
    else if (dec)  sp <= sp - W'(1);
  end

  // R10: the sequencer asks for at most one pointer action per cycle
  a_r10_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc, dec, load}));

  // R1: the pointer comes out of reset at its reset value
  a_r1_reset_value: assert property (@(posedge clk)
    !rst_n |=> sp == RESET_VAL);
endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int AW = PTR_W,
  parameter int DW = BYTE_W,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd,
  input  logic [DW-1:0] push_byte,
  input  logic [PW-1:0] call_pc,
  input  logic          pop_to_sp,
  input  logic [AW-1:0] sp,
  input  logic [DW-1:0] rdata,
  output logic          sp_inc,
  output logic          sp_dec,
  output logic          sp_load,
  output logic [AW-1:0] sp_load_val,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic [AW-1:0] ram_raddr,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] pop_byte,
  output logic [PW-1:0] ret_pc,
  output logic          isr_clr
);
  stk_state_e     st;
  stk_cmd_e       op_q;
  logic [DW-1:0]  byte_q;
  logic [PW-1:0]  pc_q;
  logic           tosp_q;
  logic [DW-1:0]  hold_q;

  // named events for the checks
  logic accept_ev;
  logic is_ret;
  logic finish_ev;

  assign accept_ev = (st == ST_IDLE) && cmd_valid && cmd_known(cmd);
  assign is_ret    = (op_q == CMD_RET) || (op_q == CMD_RETI);
  assign finish_ev = (st == ST_B);
  assign busy      = (st != ST_IDLE);
  assign ram_raddr = sp;

  always_comb begin
    sp_inc      = 1'b0;
    sp_dec      = 1'b0;
    sp_load     = 1'b0;
    sp_load_val = hold_q[AW-1:0];
    ram_we      = 1'b0;
    ram_waddr   = sp;
    ram_wdata   = byte_q;
    if (st == ST_A) begin
      unique case (op_q)
        CMD_PUSH: sp_inc = 1'b1;
        CMD_CALL: begin
          sp_inc    = 1'b1;
          ram_we    = 1'b1;
          ram_waddr = ptr_up(sp);
          ram_wdata = pc_q[DW-1:0];
        end
        default:  sp_dec = 1'b1;
      endcase
    end else if (st == ST_B) begin
      unique case (op_q)
        CMD_PUSH: ram_we = 1'b1;
        CMD_POP:  sp_load = tosp_q;
        CMD_CALL: begin
          sp_inc    = 1'b1;
          ram_we    = 1'b1;
          ram_waddr = ptr_up(sp);
          ram_wdata = pc_q[PW-1:DW];
        end
        default:  sp_dec = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op_q     <= CMD_NOP;
      byte_q   <= '0;
      pc_q     <= '0;
      tosp_q   <= 1'b0;
      hold_q   <= '0;
      done     <= 1'b0;
      isr_clr  <= 1'b0;
      pop_byte <= '0;
      ret_pc   <= '0;
    end else begin
      done    <= 1'b0;
      isr_clr <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept_ev) begin
          op_q   <= stk_cmd_e'(cmd);
          byte_q <= push_byte;
          pc_q   <= call_pc;
          tosp_q <= pop_to_sp;
          st     <= ST_A;
        end
        ST_A: begin
          hold_q <= rdata;
          st     <= ST_B;
        end
        default: begin
          done <= 1'b1;
          if (op_q == CMD_POP) pop_byte <= hold_q;
          if (is_ret) ret_pc <= pc_join(hold_q, rdata);
          if (op_q == CMD_RETI) isr_clr <= 1'b1;
          st <= ST_IDLE;
        end
      endcase
    end
  end

  // R2: a push raises the pointer before it writes
  a_r2_push_pre_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_A && op_q == CMD_PUSH) |=> sp == ptr_up($past(sp)));

  // R4: pop into the pointer leaves the popped byte there
  a_r4_pop_into_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_ev && op_q == CMD_POP && tosp_q) |=> sp == pop_byte);

  // R6: the second return step lowers the pointer again
  a_r6_ret_second_down: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_ev && is_ret) |=> sp == ptr_down($past(sp)));

  // R7: the level clear only comes with a completion
  a_r7_clr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    isr_clr |-> done);

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: the first step is always followed by the second
  a_r8_two_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_A) |=> (st == ST_B));

  // R9: a request while busy does not replace the running command
  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(op_q));
endmodule

// File: rtl/stk_unit.sv
module stk_unit
  import stk_pkg::*;
#(
  parameter int AW = PTR_W,
  parameter int DW = BYTE_W,
  parameter logic [AW-1:0] SP_RESET = 8'h07,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd,
  input  logic [DW-1:0] push_byte,
  input  logic [PW-1:0] call_pc,
  input  logic          pop_to_sp,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] pop_byte,
  output logic [PW-1:0] ret_pc,
  output logic          isr_level_clr,
  output logic [AW-1:0] sp_value
);
  logic          sp_inc, sp_dec, sp_load;
  logic [AW-1:0] sp_load_val;
  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [DW-1:0] ram_wdata, ram_rdata;

  stk_ptr #(.W(AW), .RESET_VAL(SP_RESET)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (sp_inc),
    .dec      (sp_dec),
    .load     (sp_load),
    .load_val (sp_load_val),
    .sp       (sp_value)
  );

  stk_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  stk_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd         (cmd),
    .push_byte   (push_byte),
    .call_pc     (call_pc),
    .pop_to_sp   (pop_to_sp),
    .sp          (sp_value),
    .rdata       (ram_rdata),
    .sp_inc      (sp_inc),
    .sp_dec      (sp_dec),
    .sp_load     (sp_load),
    .sp_load_val (sp_load_val),
    .ram_we      (ram_we),
    .ram_waddr   (ram_waddr),
    .ram_wdata   (ram_wdata),
    .ram_raddr   (ram_raddr),
    .busy        (busy),
    .done        (done),
    .pop_byte    (pop_byte),
    .ret_pc      (ret_pc),
    .isr_clr     (isr_level_clr)
  );

  // R5: a call save writes at the raised pointer only while busy
  a_r5_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);
endmodule

// File: tb/stk_unit_test.sv
module stk_unit_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [7:0]  push_byte = 8'h00;
  logic [15:0] call_pc = 16'h0000;
  logic        pop_to_sp = 1'b0;
  logic        busy, done, isr_level_clr;
  logic [7:0]  pop_byte, sp_value;
  logic [15:0] ret_pc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0]  b;
    logic [15:0] pc;
    logic [7:0]  sp;
    logic        clr;
    logic        use_b;
    logic        use_pc;
    string       tag;
  } exp_t;

  exp_t sb[$];

  stk_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .push_byte(push_byte), .call_pc(call_pc), .pop_to_sp(pop_to_sp),
    .busy(busy), .done(done), .pop_byte(pop_byte), .ret_pc(ret_pc),
    .isr_level_clr(isr_level_clr), .sp_value(sp_value)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic exp_t mk(input logic [7:0] b, input logic [15:0] pc,
                              input logic [7:0] sp, input logic clr,
                              input logic ub, input logic upc, input string tag);
    exp_t e;
    e.b = b; e.pc = pc; e.sp = sp; e.clr = clr; e.use_b = ub; e.use_pc = upc;
    e.tag = tag;
    return e;
  endfunction

  // monitor: compares each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (isr_level_clr === 1'b1 && done !== 1'b1)
        chk(1'b0, "R7 clear without done", 32'(isr_level_clr), 32'(0));
      if (done === 1'b1) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R9 unexpected done", 32'(done), 32'(0));
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(sp_value === e.sp, {e.tag, " pointer"}, 32'(sp_value), 32'(e.sp));
          chk(isr_level_clr === e.clr, {e.tag, " level clear"},
              32'(isr_level_clr), 32'(e.clr));
          if (e.use_b)
            chk(pop_byte === e.b, {e.tag, " byte"}, 32'(pop_byte), 32'(e.b));
          if (e.use_pc)
            chk(ret_pc === e.pc, {e.tag, " address"}, 32'(ret_pc), 32'(e.pc));
        end
      end
    end
  end

  // driver: one command, with R8 timing checks; jam requests a pop while busy
  task automatic run(input logic [2:0] c, input logic [7:0] b,
                     input logic [15:0] pc, input logic tosp, input exp_t e,
                     input bit jam);
    sb.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; push_byte = b; call_pc = pc; pop_to_sp = tosp;
    @(negedge clk);
    if (jam) begin cmd = 3'd2; pop_to_sp = 1'b0; end
    else cmd_valid = 1'b0;
    chk(busy === 1'b1, "R8 busy cycle 1", 32'(busy), 32'(1));
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R8 busy cycle 2", 32'({busy, done}), 32'(2));
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b1, "R8 done cycle", 32'({busy, done}), 32'(1));
  endtask

  task automatic push(input logic [7:0] b, input logic [7:0] sp, input string tag);
    run(3'd1, b, 16'h0, 1'b0, mk(8'h0, 16'h0, sp, 1'b0, 1'b0, 1'b0, tag), 1'b0);
  endtask

  task automatic pop(input logic tosp, input logic [7:0] b, input logic [7:0] sp,
                     input string tag);
    run(3'd2, 8'h0, 16'h0, tosp, mk(b, 16'h0, sp, 1'b0, 1'b1, 1'b0, tag), 1'b0);
  endtask

  // place the pointer at v: push v, then pop it into the pointer
  task automatic set_sp(input logic [7:0] cur, input logic [7:0] v);
    push(v, cur + 8'd1, "R2 setup push");
    pop(1'b1, v, v, "R4 setup load");
  endtask

  initial begin
    logic [7:0] hi, lo;
    repeat (3) @(negedge clk);
    chk(sp_value === 8'h07, "R1 reset pointer", 32'(sp_value), 32'h07);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", 32'({busy, done}), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp_value === 8'h07, "R1 pointer after release", 32'(sp_value), 32'h07);

    set_sp(8'h07, 8'h09);
    push(8'h23, 8'h0A, "R2 push first");
    push(8'h01, 8'h0B, "R2 push second");
    // R6: plain return
    run(3'd4, 8'h0, 16'h0, 1'b0, mk(8'h0, 16'h0123, 8'h09, 1'b0, 1'b0, 1'b1,
        "R6 return"), 1'b0);

    // R3: pops build a pointer, R4: pop into pointer
    set_sp(8'h09, 8'h2F);
    push(8'h20, 8'h30, "R2 push 20");
    push(8'h23, 8'h31, "R2 push 23");
    push(8'h01, 8'h32, "R2 push 01");
    pop(1'b0, 8'h01, 8'h31, "R3 pop high");
    hi = pop_byte;
    pop(1'b0, 8'h23, 8'h30, "R3 pop low");
    lo = pop_byte;
    chk({hi, lo} === 16'h0123, "R3 pointer pair", 32'({hi, lo}), 32'h0123);
    pop(1'b1, 8'h20, 8'h20, "R4 pop into pointer");

    // R5 call save then R7 interrupt return
    run(3'd3, 8'h0, 16'hBEEF, 1'b0, mk(8'h0, 16'h0, 8'h22, 1'b0, 1'b0, 1'b0,
        "R5 call save"), 1'b0);
    pop(1'b0, 8'hBE, 8'h21, "R5 high byte at top");
    pop(1'b0, 8'hEF, 8'h20, "R5 low byte below");
    run(3'd3, 8'h0, 16'hBEEF, 1'b0, mk(8'h0, 16'h0, 8'h22, 1'b0, 1'b0, 1'b0,
        "R5 call save again"), 1'b0);
    run(3'd5, 8'h0, 16'h0, 1'b0, mk(8'h0, 16'hBEEF, 8'h20, 1'b1, 1'b0, 1'b1,
        "R7 interrupt return"), 1'b0);

    // R9: unknown codes are ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd = 3'd0;
    @(negedge clk);
    cmd = 3'd6;
    @(negedge clk);
    cmd = 3'd7;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b0, "R9 unknown code not accepted", 32'(busy), 32'(0));
    repeat (2) @(negedge clk);
    chk(sp_value === 8'h20, "R9 pointer unchanged", 32'(sp_value), 32'h20);

    // R9: a pop requested while busy is dropped
    run(3'd1, 8'h55, 16'h0, 1'b0, mk(8'h0, 16'h0, 8'h21, 1'b0, 1'b0, 1'b0,
        "R9 push with jammed pop"), 1'b1);
    repeat (2) @(negedge clk);
    chk(sp_value === 8'h21 && busy === 1'b0, "R9 jammed pop ignored",
        32'(sp_value), 32'h21);
    pop(1'b0, 8'h55, 8'h20, "R9 pushed byte intact");

    // R10: wrap in both directions
    set_sp(8'h20, 8'hFF);
    push(8'hA5, 8'h00, "R10 push wraps to 00");
    pop(1'b0, 8'hA5, 8'hFF, "R10 pop wraps to FF");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R8 all completions seen", 32'(sb.size()), 32'(0));
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule